// File: doc/BRIEF.md
# Event Queue Enqueue Engine

This block appends one 32-bit entry to a circular event queue held in memory and hands back the updated queue state. The caller presents the queue state together with a request that carries 31 bits of event data. The queue state is a base address, a size code, a mode bit that selects small chunks or pages, the current slot index, the generation bit and a sticky wrap flag. The block checks the size code and works out the slot address. It builds the entry from the generation bit and the event data, issues one memory write, and returns the next index, generation bit and wrap flag.

The caller keeps the queue state and writes back what the block returns. Each entry carries a generation bit that inverts on every pass through the queue, so a reader can tell new entries from stale ones without a shared pointer. The sticky wrap flag records that at least one wrap has happened since software last cleared it. The clear request arrives with the enqueue, on a separate input.

Top module: `evq_enqueue_engine`

## Requirements
- R1: With `descChunk`=1 (small-chunk mode) the queue holds 32 << `descSize` entries, and a size code above 4 is illegal.
- R2: With `descChunk`=0 (page mode) the queue holds 1024 << `descSize` entries, and a size code above 12 is illegal.
- R3: The write address `memAddr` is `descBase` + 4 × `descIndex`, modulo 2^ADDR_W.
- R4: The entry word has the generation bit in bit 31 and `reqData[30:0]` in bits 30:0. It is driven big-endian: `memData[7:0]` carries entry bits 31:24, `memData[15:8]` bits 23:16, `memData[23:16]` bits 15:8 and `memData[31:24]` bits 7:0.
- R5: After a successful write, `newIndex` = `descIndex`+1 and `newGen` = `descGen`. When `descIndex`+1 equals the entry count, `newIndex` is 0 and `newGen` is the inverse of `descGen`.
- R6: A successful write that wraps returns `newFlip`=1. A successful write that does not wrap returns 0 if `flipClear` was high at acceptance, and `descFlip` otherwise.
- R7: An illegal size code produces no memory write. `doneValid` rises in the cycle after acceptance with `errSize`=1 and with `newIndex`, `newGen` and `newFlip` equal to the inputs.
- R8: `reqReady` is high only while no request is in progress. A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. `doneValid` pulses for one cycle after the edge on which `memAck` is seen.
- R9: A write that is acknowledged with `memErr`=1 returns `errMem`=1 and leaves index, generation bit and flag equal to the inputs.
- R10: While `memValid` is high and `memAck` is low, `memValid`, `memAddr` and `memData` stay unchanged.
- R11: After reset, `reqReady`=1, `memValid`=0, `doneValid`=0, and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| descBase | input | ADDR_W | Queue base byte address |
| descSize | input | SIZE_W | Queue size code |
| descChunk | input | 1 | 1: small-chunk mode, 0: page mode |
| descIndex | input | 22 | Current slot index |
| descGen | input | 1 | Current generation bit |
| descFlip | input | 1 | Current sticky wrap flag |
| flipClear | input | 1 | Clear the wrap flag, sampled with the request |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Block can accept a request |
| reqData | input | 31 | Event data |
| memValid | output | 1 | Memory write request |
| memAddr | output | ADDR_W | Memory write byte address |
| memData | output | 32 | Entry word, big-endian byte lanes |
| memAck | input | 1 | Memory write completed |
| memErr | input | 1 | Write failed; valid with memAck |
| doneValid | output | 1 | One-cycle result strobe |
| newIndex | output | 22 | Updated slot index |
| newGen | output | 1 | Updated generation bit |
| newFlip | output | 1 | Updated sticky wrap flag |
| errSize | output | 1 | Illegal size code on the last request |
| errMem | output | 1 | Memory error on the last request |

## Verification
Wrong internal state shows up at the ports on the next request. An incorrect entry count moves the wrap point, so the bench aims at the last slot of the smallest and the largest queue in each mode and sees `newIndex` not return to 0 within the same request. An incorrect captured index or generation bit appears as a wrong `memAddr` or a wrong bit in the first byte lane, as soon as `memValid` rises. Illegal size codes, memory errors and flag clears are checked on the `doneValid` cycle of the request that caused them.

// File: rtl/evq_pkg.sv
package evq_pkg;
  // Log2 of the entry count for size code 0 in each mode
  localparam int SMALL_LOG_ENTRIES = 5;
  localparam int PAGE_LOG_ENTRIES  = 10;
  // Largest legal size code in each mode
  localparam int SMALL_MAX_CODE    = 4;
  localparam int PAGE_MAX_CODE     = 12;
  // Index width covers the largest queue
  localparam int IDX_W = PAGE_LOG_ENTRIES + PAGE_MAX_CODE;
  localparam int CNT_W = IDX_W + 1;

  typedef struct packed {
    logic load;         // capture request and queue state
    logic commitWrite;  // memory acknowledged, store results
    logic commitSkip;   // illegal size, store error result
  } evqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_RESP  = 2'd2
  } evqState_t;
endpackage

// File: rtl/evq_datapath.sv
module evq_datapath
  import evq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  evqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] descBase,
  input  logic [SIZE_W-1:0] descSize,
  input  logic              descChunk,
  input  logic [IDX_W-1:0]  descIndex,
  input  logic              descGen,
  input  logic              descFlip,
  input  logic              flipClear,
  input  logic [30:0]       reqData,
  input  logic              memErr,
  output logic              sizeBad,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic [IDX_W-1:0]  newIndex,
  output logic              newGen,
  output logic              newFlip,
  output logic              errSize,
  output logic              errMem
);
  function automatic logic codeLegal(input logic chunk, input logic [SIZE_W-1:0] code);
    if (chunk) return int'(code) <= SMALL_MAX_CODE;
    else       return int'(code) <= PAGE_MAX_CODE;
  endfunction

  function automatic logic [CNT_W-1:0] entriesOf(input logic chunk, input logic [SIZE_W-1:0] code);
    if (chunk) return CNT_W'(1) << (SMALL_LOG_ENTRIES + int'(code));
    else       return CNT_W'(1) << (PAGE_LOG_ENTRIES + int'(code));
  endfunction

  // Captured request
  logic [ADDR_W-1:0] capBase;
  logic [SIZE_W-1:0] capSize;
  logic              capChunk;
  logic [IDX_W-1:0]  capIdx;
  logic              capGen;
  logic              capFlip;
  logic              capClear;
  logic [30:0]       capData;

  logic [CNT_W-1:0]  capCount;
  logic [CNT_W-1:0]  incIdx;
  logic              wrap;
  logic [IDX_W-1:0]  nextIdx;
  logic [31:0]       entryWord;

  assign sizeBad = !codeLegal(descChunk, descSize);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capBase  <= '0;
      capSize  <= '0;
      capChunk <= 1'b0;
      capIdx   <= '0;
      capGen   <= 1'b0;
      capFlip  <= 1'b0;
      capClear <= 1'b0;
      capData  <= '0;
    end else if (strobe.load) begin
      capBase  <= descBase;
      capSize  <= descSize;
      capChunk <= descChunk;
      capIdx   <= descIndex;
      capGen   <= descGen;
      capFlip  <= descFlip;
      capClear <= flipClear;
      capData  <= reqData;
    end
  end

  always_comb begin
    capCount  = entriesOf(capChunk, capSize);
    incIdx    = {1'b0, capIdx} + CNT_W'(1);
    wrap      = incIdx >= capCount;
    nextIdx   = wrap ? '0 : incIdx[IDX_W-1:0];
    entryWord = {capGen, capData};
  end

  assign memAddr = capBase + ADDR_W'({capIdx, 2'b00});

  // Big-endian lanes: most significant entry byte in the lowest lane
  genvar lane;
  generate
    for (lane = 0; lane < 4; lane++) begin : g_lane
      assign memData[8*lane +: 8] = entryWord[8*(3-lane) +: 8];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newIndex <= '0;
      newGen   <= 1'b0;
      newFlip  <= 1'b0;
      errSize  <= 1'b0;
      errMem   <= 1'b0;
    end else if (strobe.commitSkip) begin
      newIndex <= descIndex;
      newGen   <= descGen;
      newFlip  <= descFlip;
      errSize  <= 1'b1;
      errMem   <= 1'b0;
    end else if (strobe.commitWrite) begin
      errSize <= 1'b0;
      if (memErr) begin
        newIndex <= capIdx;
        newGen   <= capGen;
        newFlip  <= capFlip;
        errMem   <= 1'b1;
      end else begin
        newIndex <= nextIdx;
        newGen   <= capGen ^ wrap;
        newFlip  <= wrap ? 1'b1 : (capFlip & ~capClear);
        errMem   <= 1'b0;
      end
    end
  end

  // R5: a successful commit leaves the index inside the queue
  assert_index_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitWrite && !memErr |=> {1'b0, newIndex} < capCount);

  // R6: a result index of zero after a good write means a wrap, so the flag is set
  assert_wrap_sets_flip_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitWrite && !memErr && (nextIdx == '0) |=> newFlip);

  // R9: a failed write returns the captured generation bit
  assert_err_keeps_gen_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitWrite && memErr |=> errMem && (newGen == $past(capGen)));
endmodule

// File: rtl/evq_control.sv
module evq_control
  import evq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       sizeBad,
  input  logic       memAck,
  output logic       reqReady,
  output logic       memValid,
  output logic       doneValid,
  output evqStrobe_t strobe
);
  evqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load       = 1'b1;
          strobe.commitSkip = sizeBad;
          stateNext         = sizeBad ? ST_RESP : ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (memAck) begin
          strobe.commitWrite = 1'b1;
          stateNext          = ST_RESP;
        end
      end
      ST_RESP:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady  = (state == ST_IDLE);
  assign memValid  = (state == ST_WRITE);
  assign doneValid = (state == ST_RESP);

  // R7: an illegal size skips the write and answers on the next cycle
  assert_size_skip_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqReady && reqValid && sizeBad |=> !memValid && doneValid);

  // R8: an acknowledged write is answered on the next cycle, with no new acceptance
  assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memAck |=> doneValid && !reqReady);

  // R8: a result strobe lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
endmodule

// File: rtl/evq_enqueue_engine.sv
module evq_enqueue_engine
  import evq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] descBase,
  input  logic [SIZE_W-1:0] descSize,
  input  logic              descChunk,
  input  logic [21:0]       descIndex,
  input  logic              descGen,
  input  logic              descFlip,
  input  logic              flipClear,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [30:0]       reqData,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  input  logic              memAck,
  input  logic              memErr,
  output logic              doneValid,
  output logic [21:0]       newIndex,
  output logic              newGen,
  output logic              newFlip,
  output logic              errSize,
  output logic              errMem
);
  evqStrobe_t strobe;
  logic       sizeBad;

  evq_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .sizeBad   (sizeBad),
    .memAck    (memAck),
    .reqReady  (reqReady),
    .memValid  (memValid),
    .doneValid (doneValid),
    .strobe    (strobe)
  );

  evq_datapath #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .descBase  (descBase),
    .descSize  (descSize),
    .descChunk (descChunk),
    .descIndex (descIndex),
    .descGen   (descGen),
    .descFlip  (descFlip),
    .flipClear (flipClear),
    .reqData   (reqData),
    .memErr    (memErr),
    .sizeBad   (sizeBad),
    .memAddr   (memAddr),
    .memData   (memData),
    .newIndex  (newIndex),
    .newGen    (newGen),
    .newFlip   (newFlip),
    .errSize   (errSize),
    .errMem    (errMem)
  );

  // R10: the write request holds still until it is acknowledged
  assert_write_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memAck |=> memValid && $stable(memAddr) && $stable(memData));
endmodule

// File: tb/evq_enqueue_engine_tb.sv
module evq_enqueue_engine_tb;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] descBase = '0;
  logic [SIZE_W-1:0] descSize = '0;
  logic              descChunk = 1'b0;
  logic [21:0]       descIndex = '0;
  logic              descGen = 1'b0;
  logic              descFlip = 1'b0;
  logic              flipClear = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [30:0]       reqData = '0;
  logic              memValid;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0]       memData;
  logic              memAck = 1'b0;
  logic              memErr = 1'b0;
  logic              doneValid;
  logic [21:0]       newIndex;
  logic              newGen;
  logic              newFlip;
  logic              errSize;
  logic              errMem;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  evq_enqueue_engine #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dut (
    .clk(clk), .rstN(rstN), .descBase(descBase), .descSize(descSize),
    .descChunk(descChunk), .descIndex(descIndex), .descGen(descGen),
    .descFlip(descFlip), .flipClear(flipClear), .reqValid(reqValid),
    .reqReady(reqReady), .reqData(reqData), .memValid(memValid),
    .memAddr(memAddr), .memData(memData), .memAck(memAck), .memErr(memErr),
    .doneValid(doneValid), .newIndex(newIndex), .newGen(newGen),
    .newFlip(newFlip), .errSize(errSize), .errMem(errMem)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int entriesModel(input logic chunk, input logic [3:0] size);
    return chunk ? (32 << size) : (1024 << size);
  endfunction

  function automatic bit legalModel(input logic chunk, input logic [3:0] size);
    return chunk ? (size <= 4) : (size <= 12);
  endfunction

  function automatic logic [31:0] laneModel(input logic gen, input logic [30:0] data);
    logic [31:0] w;
    w = {gen, data};
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic enq(input logic [31:0] base, input logic [3:0] size, input logic chunk,
                     input logic [21:0] idx, input logic gen, input logic flip,
                     input logic clr, input logic [30:0] data, input int delay,
                     input logic merr);
    logic [31:0] expAddr, expData;
    logic [21:0] expIdx;
    logic        expGen, expFlip;
    int          n;
    @(negedge clk);
    check(reqReady == 1'b1, "R8", "ready before request", 64'(reqReady), 64'd1);
    descBase = base; descSize = size; descChunk = chunk; descIndex = idx;
    descGen = gen; descFlip = flip; flipClear = clr; reqData = data; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (!legalModel(chunk, size)) begin
      check(memValid == 1'b0, chunk ? "R1" : "R2", "no write on illegal size", 64'(memValid), 64'd0);
      check(doneValid && errSize && !errMem, "R7", "size error result",
            64'({doneValid, errSize, errMem}), 64'b110);
      check(newIndex == idx && newGen == gen && newFlip == flip, "R7", "fields unchanged",
            64'({newIndex, newGen, newFlip}), 64'({idx, gen, flip}));
    end else begin
      expAddr = base + {8'd0, idx, 2'b00};
      expData = laneModel(gen, data);
      n = entriesModel(chunk, size);
      for (int k = 0; k <= delay; k++) begin
        check(memValid == 1'b1, "R10", "write held", 64'(memValid), 64'd1);
        check(memAddr == expAddr, "R3", "address", 64'(memAddr), 64'(expAddr));
        check(memData == expData, "R4", "entry lanes", 64'(memData), 64'(expData));
        check(reqReady == 1'b0, "R8", "busy while writing", 64'(reqReady), 64'd0);
        if (k < delay) @(negedge clk);
      end
      memAck = 1'b1; memErr = merr;
      @(posedge clk);
      @(negedge clk);
      memAck = 1'b0; memErr = 1'b0;
      if (merr) begin
        expIdx = idx; expGen = gen; expFlip = flip;
      end else if (int'(idx) + 1 >= n) begin
        expIdx = '0; expGen = ~gen; expFlip = 1'b1;
      end else begin
        expIdx = idx + 22'd1; expGen = gen; expFlip = clr ? 1'b0 : flip;
      end
      check(doneValid && !errSize && (errMem == merr), merr ? "R9" : "R8", "done strobe",
            64'({doneValid, errSize, errMem}), 64'({1'b1, 1'b0, merr}));
      check(newIndex == expIdx, merr ? "R9" : (chunk ? "R1" : "R2"), "index/R5",
            64'(newIndex), 64'(expIdx));
      check(newGen == expGen, merr ? "R9" : "R5", "generation", 64'(newGen), 64'(expGen));
      check(newFlip == expFlip, merr ? "R9" : "R6", "wrap flag", 64'(newFlip), 64'(expFlip));
    end
    @(negedge clk);
    check(!doneValid && reqReady, "R8", "single pulse", 64'({doneValid, reqReady}), 64'b01);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h00c0ffee);
    repeat (3) @(negedge clk);
    check(reqReady && !memValid && !doneValid, "R11", "reset handshake",
          64'({reqReady, memValid, doneValid}), 64'b100);
    check(newIndex == 0 && !newGen && !newFlip && !errSize && !errMem, "R11", "reset results",
          64'({newIndex, newGen, newFlip, errSize, errMem}), 64'd0);
    rstN = 1'b1;

    // Wrap at the smallest and largest queue of each mode
    enq(32'h1000_0000, 4'd0,  1'b1, 22'd31,      1'b0, 1'b0, 1'b0, 31'h1234_5678, 0, 1'b0);
    enq(32'h2000_0000, 4'd4,  1'b1, 22'd511,     1'b1, 1'b0, 1'b0, 31'h7fff_ffff, 2, 1'b0);
    enq(32'h3000_0000, 4'd0,  1'b0, 22'd1023,    1'b1, 1'b1, 1'b1, 31'h0000_0001, 1, 1'b0);
    enq(32'hffff_fff0, 4'd12, 1'b0, 22'h3f_ffff, 1'b0, 1'b0, 1'b0, 31'h5a5a_a5a5, 0, 1'b0);
    // Illegal sizes
    enq(32'h4000_0000, 4'd5,  1'b1, 22'd7,       1'b1, 1'b1, 1'b0, 31'h1, 0, 1'b0);
    enq(32'h4000_0000, 4'd13, 1'b0, 22'd9,       1'b0, 1'b1, 1'b1, 31'h2, 0, 1'b0);
    enq(32'h4000_0000, 4'd15, 1'b0, 22'd3,       1'b1, 1'b0, 1'b0, 31'h3, 0, 1'b0);
    // Sticky flag kept, then cleared
    enq(32'h5000_0100, 4'd1,  1'b1, 22'd10,      1'b1, 1'b1, 1'b0, 31'h0abc_def0, 0, 1'b0);
    enq(32'h5000_0100, 4'd1,  1'b1, 22'd11,      1'b1, 1'b1, 1'b1, 31'h0abc_def1, 0, 1'b0);
    // Clear loses to a wrap
    enq(32'h5000_0100, 4'd1,  1'b1, 22'd63,      1'b1, 1'b0, 1'b1, 31'h0abc_def2, 0, 1'b0);
    // Memory error at the wrap slot
    enq(32'h6000_0000, 4'd0,  1'b1, 22'd31,      1'b0, 1'b0, 1'b1, 31'h6666_6666, 3, 1'b1);

    for (int it = 0; it < 150; it++) begin
      logic        ch;
      logic [3:0]  sz;
      int          n;
      logic [21:0] ix;
      ch = 1'($urandom);
      sz = ($urandom % 8 == 0) ? 4'($urandom) : (ch ? 4'($urandom % 5) : 4'($urandom % 13));
      n  = legalModel(ch, sz) ? entriesModel(ch, sz) : 16;
      ix = ($urandom % 4 == 0) ? 22'(n - 1) : 22'($urandom % n);
      enq($urandom, sz, ch, ix, 1'($urandom), 1'($urandom), 1'($urandom),
          31'($urandom), int'($urandom % 4), ($urandom % 8 == 0));
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule